// File: doc/BRIEF.md
# Slow Clock Calibration Counter

This block measures the period of one of four low-frequency clocks against the fast reference clock it runs on. Software selects a slow source, asks for a number of slow-clock periods to observe and chooses between a single measurement and a repeating one. The block waits for the first detected rising edge of the selected slow clock, then counts reference cycles until the requested number of further rising edges has arrived. It reports that total, a one-cycle done pulse and a sticky timeout flag. Each slow clock enters as a level sampled by the reference clock through a two-flop synchroniser with a rising-edge detector.

A dead or missing oscillator is caught by a timeout window. The window length is the requested period count shifted left by an amount that depends on the source. In repeating mode the block starts a new measurement each time one finishes. A later request with the same source and count is then answered at once with the most recent result.

The control state machine has three states. ST_IDLE means no measurement is running. ST_ARM means a measurement is waiting for the first slow edge. ST_COUNT means reference cycles are being counted. The transitions are:
- start (count non-zero): any state to ST_ARM.
- start (count zero): any state to ST_IDLE.
- first edge: ST_ARM to ST_COUNT.
- final edge in single mode: ST_COUNT to ST_IDLE.
- final edge in repeating mode: ST_COUNT to ST_COUNT, with the counters cleared.
- window expiry: ST_ARM or ST_COUNT to ST_IDLE.
- reuse request: no change of state.

Top module: `slowcal_meter`

## Requirements
- R1: After reset, busy_o, done_o and timeout_o are 0 and result_o is 0.
- R2: src_i picks the slow input slow_lvl_i[src_i]. Code 0 is the already-muxed slow clock, 1 is the fast RC divided by 256, 2 is the 32 kHz crystal and 3 is the internal RC slow oscillator. The selection is latched when the start is accepted.
- R3: result_o equals the number of reference cycles from the first detected slow rising edge to the ncyc_i-th rising edge after it. A slow clock of period P therefore gives ncyc_i*P.
- R4: The window is ncyc_i shifted left by SH_MUX (default 12) for code 0, by SH_RC256 (12) for code 1, by SH_XTAL (12) for code 2 and by SH_RCSLOW (10) for code 3. If the count has not finished when the window ends, done_o and timeout_o rise at the edge that falls window-length edges after the edge that accepted start, and result_o reads 0.
- R5: A request with ncyc_i = 0 raises done_o in the cycle right after the accepting edge, with result_o 0, timeout_o 0 and busy_o 0.
- R6: done_o is high for exactly one cycle per answer. After a single-mode measurement, busy_o is 0 and result_o holds its value until the next start.
- R7: A start that begins a new measurement clears timeout_o, done_o and result_o in the next cycle and raises busy_o.
- R8: mode_i = 1 selects repeating mode. The first request waits for a full measurement, and later measurements restart on the final edge and run without pulsing done_o.
- R9: In repeating mode, once a result exists, a request with mode_i = 1 and the same source and count raises done_o in the cycle right after the accepting edge and returns the latest completed result.
- R10: A repeating-mode request whose source or count differs from the running one discards the stored result and waits for a fresh measurement.
- R11: The reference count is CNT_W bits wide and saturates at all ones instead of wrapping.
- R12: A timeout in repeating mode stops the measurement (busy_o 0) and discards the stored result, so the next identical request measures afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle measurement request |
| mode_i | input | 1 | 0 single measurement, 1 repeating measurement |
| src_i | input | 2 | Slow source code |
| ncyc_i | input | REQ_W | Number of slow periods to observe |
| slow_lvl_i | input | 4 | Raw levels of the four slow clocks |
| busy_o | output | 1 | A measurement is armed or counting |
| done_o | output | 1 | One-cycle answer pulse |
| timeout_o | output | 1 | Last measurement ended on the window limit |
| result_o | output | CNT_W | Reference cycles counted, 0 on timeout |

## Verification
A wrong edge counter or a wrong source latch shows up as a result that is a whole multiple of the slow period away from ncyc_i*P. It is visible on result_o in the same cycle as the done pulse. A wrong shift selection shows up as a timeout that arrives on the wrong edge. This is checked exactly by counting edges from the accepting edge. A stuck or leaking reuse flag shows up within one cycle of a repeating request: done_o arrives too early or too late, or the result is stale. A stuck state register shows up as busy_o failing to drop after a single measurement or a timeout.

// File: rtl/slowcal_pkg.sv
package slowcal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_COUNT = 2'd2
    } cal_state_t;

    localparam logic [1:0] SRC_MUX    = 2'd0;
    localparam logic [1:0] SRC_RC256  = 2'd1;
    localparam logic [1:0] SRC_XTAL   = 2'd2;
    localparam logic [1:0] SRC_RCSLOW = 2'd3;

    function automatic int max_shift(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/slowcal_edge_sync.sv
module slowcal_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= lvl_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise_o = sync_q & ~prev_q;

    // a detected rise never repeats on the following cycle (supports R3)
    assert_rise_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/slowcal_sat_counter.sv
module slowcal_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    output logic [W-1:0] inc_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_q;

    assign inc_o = (cnt_q == TOP) ? TOP : cnt_q + {{(W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (en_i)   cnt_q <= inc_o;
    end

    assert_no_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clr_i && cnt_q == TOP) |=> (cnt_q == TOP));
endmodule

// File: rtl/slowcal_window_timer.sv
module slowcal_window_timer #(
    parameter int W = 27
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic [W-1:0] limit_i,
    output logic         hit_o
);
    logic [W-1:0] cnt_q;

    assign hit_o = en_i && (limit_i != '0) &&
                   (cnt_q == (limit_i - {{(W-1){1'b0}}, 1'b1}));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (en_i)   cnt_q <= cnt_q + {{(W-1){1'b0}}, 1'b1};
    end

    assert_window_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && limit_i != '0) |-> (cnt_q < limit_i));
endmodule

// File: rtl/slowcal_meter.sv
module slowcal_meter
    import slowcal_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int REQ_W     = 15,
    parameter int SH_MUX    = 12,
    parameter int SH_RC256  = 12,
    parameter int SH_XTAL   = 12,
    parameter int SH_RCSLOW = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             mode_i,
    input  logic [1:0]       src_i,
    input  logic [REQ_W-1:0] ncyc_i,
    input  logic [3:0]       slow_lvl_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             timeout_o,
    output logic [CNT_W-1:0] result_o
);
    localparam int NSRC   = 4;
    localparam int MAX_SH = max_shift(SH_MUX, SH_RC256, SH_XTAL, SH_RCSLOW);
    localparam int TMR_W  = REQ_W + MAX_SH;

    cal_state_t       state_q, state_d;
    logic [1:0]       cfg_src_q;
    logic [REQ_W-1:0] cfg_n_q;
    logic [REQ_W-1:0] edge_cnt_q;
    logic             cyc_q, valid_q, pend_q, done_q, tmo_q;
    logic [CNT_W-1:0] res_q;

    logic [NSRC-1:0]  rise;
    logic             edge_sel, last_edge, measuring, fin, tmo_ev;
    logic             reuse, fresh, zero_req;
    logic             ref_clr, ref_en, tmr_clr, tmr_hit;
    logic [CNT_W-1:0] ref_inc;
    logic [TMR_W-1:0] n_ext, thresh;

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_sync
            slowcal_edge_sync u_sync (
                .clk    (clk),
                .rst_n  (rst_n),
                .lvl_i  (slow_lvl_i[g]),
                .rise_o (rise[g])
            );
        end
    endgenerate

    assign edge_sel  = rise[cfg_src_q];
    assign last_edge = ({1'b0, edge_cnt_q} + {{REQ_W{1'b0}}, 1'b1}) == {1'b0, cfg_n_q};
    assign measuring = (state_q != ST_IDLE);
    assign fin       = (state_q == ST_COUNT) && edge_sel && last_edge;
    assign tmo_ev    = measuring && tmr_hit && !fin;
    assign reuse     = start_i && mode_i && valid_q &&
                       (src_i == cfg_src_q) && (ncyc_i == cfg_n_q);
    assign fresh     = start_i && !reuse;
    assign zero_req  = (ncyc_i == '0);

    // window length per source
    assign n_ext = {{MAX_SH{1'b0}}, cfg_n_q};
    always_comb begin
        unique case (cfg_src_q)
            SRC_MUX:    thresh = n_ext << SH_MUX;
            SRC_RC256:  thresh = n_ext << SH_RC256;
            SRC_XTAL:   thresh = n_ext << SH_XTAL;
            SRC_RCSLOW: thresh = n_ext << SH_RCSLOW;
            default:    thresh = n_ext << MAX_SH;
        endcase
    end

    assign ref_clr = fresh || ((state_q == ST_ARM) && edge_sel) || fin;
    assign ref_en  = (state_q == ST_COUNT);
    assign tmr_clr = fresh || fin;

    slowcal_sat_counter #(.W(CNT_W)) u_refcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (ref_clr),
        .en_i  (ref_en),
        .inc_o (ref_inc)
    );

    slowcal_window_timer #(.W(TMR_W)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (tmr_clr),
        .en_i    (measuring),
        .limit_i (thresh),
        .hit_o   (tmr_hit)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (fresh) begin
            state_d = zero_req ? ST_IDLE : ST_ARM;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_ARM: begin
                    if (tmo_ev)        state_d = ST_IDLE;
                    else if (edge_sel) state_d = ST_COUNT;
                end
                ST_COUNT: begin
                    if (tmo_ev)              state_d = ST_IDLE;
                    else if (fin && !cyc_q)  state_d = ST_IDLE;
                end
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_src_q  <= SRC_MUX;
            cfg_n_q    <= '0;
            edge_cnt_q <= '0;
            cyc_q      <= 1'b0;
            valid_q    <= 1'b0;
            pend_q     <= 1'b0;
            done_q     <= 1'b0;
            tmo_q      <= 1'b0;
            res_q      <= '0;
        end else if (fresh) begin
            cfg_src_q  <= src_i;
            cfg_n_q    <= ncyc_i;
            cyc_q      <= mode_i;
            edge_cnt_q <= '0;
            valid_q    <= 1'b0;
            pend_q     <= !zero_req;
            done_q     <= zero_req;
            tmo_q      <= 1'b0;
            res_q      <= '0;
        end else begin
            done_q <= reuse;
            if (fin) begin
                res_q      <= ref_inc;
                edge_cnt_q <= '0;
                pend_q     <= 1'b0;
                if (cyc_q)  valid_q <= 1'b1;
                if (pend_q) done_q  <= 1'b1;
            end else if ((state_q == ST_COUNT) && edge_sel) begin
                edge_cnt_q <= edge_cnt_q + {{(REQ_W-1){1'b0}}, 1'b1};
            end
            if (tmo_ev) begin
                tmo_q      <= 1'b1;
                done_q     <= 1'b1;
                res_q      <= '0;
                valid_q    <= 1'b0;
                pend_q     <= 1'b0;
                edge_cnt_q <= '0;
            end
        end
    end

    assign busy_o    = measuring;
    assign done_o    = done_q;
    assign timeout_o = tmo_q;
    assign result_o  = res_q;

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !start_i) |=> !done_q);

    assert_tmo_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (result_o == '0));

    assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fresh && !zero_req) |=> (!timeout_o && !done_o && busy_o));

    assert_valid_cycling_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (cyc_q && busy_o));

    assert_tmo_stops_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> !busy_o);
endmodule

// File: tb/slowcal_meter_bench.sv
module slowcal_meter_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, start_s = 1'b0;
    logic        mode = 1'b0;
    logic [1:0]  src = 2'd0;
    logic [14:0] ncyc = '0;
    logic [3:0]  lvl = '0;
    logic        busy, done, tmo, busy_s, done_s, tmo_s;
    logic [31:0] result;
    logic [7:0]  result_s;

    int nchk = 0, nbad = 0;
    bit finished = 1'b0;
    int half [4];
    int ctr  [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    slowcal_meter u_slowcal_meter (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .src_i(src),
        .ncyc_i(ncyc), .slow_lvl_i(lvl), .busy_o(busy), .done_o(done),
        .timeout_o(tmo), .result_o(result)
    );

    slowcal_meter #(.CNT_W(8)) u_slowcal_meter_sat (
        .clk(clk), .rst_n(rst_n), .start_i(start_s), .mode_i(mode), .src_i(src),
        .ncyc_i(ncyc), .slow_lvl_i(lvl), .busy_o(busy_s), .done_o(done_s),
        .timeout_o(tmo_s), .result_o(result_s)
    );

    // slow clock generators: half period in reference cycles, 0 holds the level
    initial begin
        half[0] = 10; half[1] = 20; half[2] = 32; half[3] = 15;
        for (int i = 0; i < 4; i++) ctr[i] = 0;
        forever begin
            @(negedge clk);
            for (int i = 0; i < 4; i++) begin
                if (half[i] != 0) begin
                    ctr[i]++;
                    if (ctr[i] >= half[i]) begin
                        lvl[i] = ~lvl[i];
                        ctr[i] = 0;
                    end
                end
            end
        end
    end

    task automatic check(input string tag, input longint act, input longint exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic req(input bit sat, input logic m, input logic [1:0] s, input int n);
        @(negedge clk);
        mode = m; src = s; ncyc = n[14:0];
        if (sat) start_s = 1'b1; else start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0; start_s = 1'b0;
    endtask

    // edges counted after the accepting edge until done is seen
    task automatic wait_done(input bit sat, input int limit, output int k);
        k = 0;
        while (!(sat ? done_s : done) && k < limit) begin
            @(posedge clk); #1;
            k++;
        end
    endtask

    task automatic t_reset();
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 timeout", tmo, 0);
        check("R1 result", result, 0);
    endtask

    task automatic t_sources();
        int k;
        for (int s = 0; s < 4; s++) begin
            req(0, 1'b0, s[1:0], 4);
            wait_done(0, 5000, k);
            check($sformatf("R2 R3 src%0d result", s), result, 4 * 2 * half[s]);
            check($sformatf("R2 src%0d timeout", s), tmo, 0);
        end
    endtask

    task automatic t_hold();
        int k;
        logic [31:0] r0;
        req(0, 1'b0, 2'd1, 2);
        wait_done(0, 5000, k);
        r0 = result;
        check("R3 two periods", r0, 80);
        @(posedge clk); #1;
        check("R6 done one cycle", done, 0);
        repeat (60) @(posedge clk);
        #1;
        check("R6 result held", result, r0);
        check("R6 idle after single", busy, 0);
    endtask

    task automatic t_zero();
        int k;
        req(0, 1'b0, 2'd2, 0);
        wait_done(0, 100, k);
        check("R5 done latency", k, 0);
        check("R5 result", result, 0);
        check("R5 timeout", tmo, 0);
        check("R5 busy", busy, 0);
    endtask

    task automatic t_timeout(input int s, input int n, input int sh);
        int k, keep;
        keep = half[s];
        half[s] = 0;
        req(0, 1'b0, s[1:0], n);
        wait_done(0, 20000, k);
        check($sformatf("R4 src%0d window", s), k, n << sh);
        check("R4 timeout flag", tmo, 1);
        check("R4 result zero", result, 0);
        check("R4 busy after", busy, 0);
        half[s] = keep;
    endtask

    task automatic t_clear();
        int k;
        req(0, 1'b0, 2'd0, 3);
        check("R7 timeout cleared", tmo, 0);
        check("R7 done low", done, 0);
        check("R7 busy", busy, 1);
        wait_done(0, 5000, k);
        check("R7 new result", result, 60);
    endtask

    task automatic t_cycling();
        int k, pulses;
        req(0, 1'b1, 2'd1, 3);
        wait_done(0, 5000, k);
        check("R8 first waits", (k > 0) ? 1 : 0, 1);
        check("R8 first result", result, 120);
        pulses = 0;
        for (int i = 0; i < 400; i++) begin
            @(posedge clk); #1;
            if (done) pulses++;
            if (!busy) pulses += 1000;
        end
        check("R8 silent restart, busy held", pulses, 0);
        check("R8 background result", result, 120);
    endtask

    task automatic t_reuse();
        int k;
        req(0, 1'b1, 2'd1, 3);
        wait_done(0, 100, k);
        check("R9 reuse latency", k, 0);
        check("R9 reuse result", result, 120);
        half[1] = 25;
        repeat (800) @(posedge clk);
        req(0, 1'b1, 2'd1, 3);
        wait_done(0, 100, k);
        check("R9 latest latency", k, 0);
        check("R9 latest result", result, 150);
    endtask

    task automatic t_reconf();
        int k;
        req(0, 1'b1, 2'd1, 2);
        wait_done(0, 5000, k);
        check("R10 count change waits", (k > 0) ? 1 : 0, 1);
        check("R10 count change result", result, 100);
        req(0, 1'b1, 2'd3, 2);
        wait_done(0, 5000, k);
        check("R10 source change waits", (k > 0) ? 1 : 0, 1);
        check("R10 source change result", result, 60);
    endtask

    task automatic t_cyc_timeout();
        int k;
        half[3] = 0;
        req(0, 1'b1, 2'd3, 1);
        wait_done(0, 5000, k);
        check("R12 window", k, 1024);
        check("R12 timeout", tmo, 1);
        check("R12 stopped", busy, 0);
        req(0, 1'b1, 2'd3, 1);
        wait_done(0, 5000, k);
        check("R12 no reuse", k, 1024);
        half[3] = 15;
    endtask

    task automatic t_sat();
        int k;
        req(1, 1'b0, 2'd2, 3);
        wait_done(1, 5000, k);
        check("R11 below limit", result_s, 192);
        req(1, 1'b0, 2'd2, 5);
        wait_done(1, 5000, k);
        check("R11 saturated", result_s, 255);
        check("R11 no timeout", tmo_s, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(posedge clk);
        #1;
        t_reset();
        t_sources();
        t_hold();
        t_zero();
        t_timeout(2, 1, 12);
        t_timeout(3, 2, 10);
        t_timeout(0, 1, 12);
        t_timeout(1, 1, 12);
        t_clear();
        t_cycling();
        t_reuse();
        t_reconf();
        t_cyc_timeout();
        t_sat();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nbad++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
            $finish;
        end
    end
endmodule